// File: doc/BRIEF.md
# GPIO Bank with Pin Ownership Override

This block is one bank of general-purpose I/O pins behind a simple word-addressed register port. Software drives pins through write-one-to-act set and clear registers for the output value and the direction, switches each pin's pull resistor on or off, and picks a pull direction. Each pin is handed to one of four owners: the GPIO logic itself or one of three on-chip peripherals (A, B, C). The pad-side outputs are the drive enable, drive value, pull enable, pull direction, a two-bit owner code and a slew-control bit per pin.

An external force input lets platform logic hand pins back to GPIO control without touching the select registers. While it is high, every pin whose keep-owner bit is 0 is driven by the GPIO registers. Pins whose keep-owner bit is 1 stay with their selected owner. Dropping the input restores the selected owners at once. Pad inputs pass through a two-flop synchronizer before software reads them.

Top module: `gpio_mux_bank`

## Requirements
- R1: After reset, every pin is GPIO-owned (owner code 0) and is an input (pad_oe all 0) with its pull on (pad_pull_en all 1) and pulled down (pad_pull_up all 0). pad_slew is all 0, and the keep-owner register (offset 9) reads all ones.
- R2: Writing offset 1 sets every data bit written as 1, and writing offset 2 clears every data bit written as 1. Zero bits leave data unchanged. Offset 0 writes data directly, and offset 11 reads the data register back.
- R3: Offsets 4 and 5 set and clear direction bits in the same write-one way (1 = output). Offset 3 reads the direction and may be written directly.
- R4: A pin's owner code is {B-select bit, A-select bit}, from offsets 8 and 7. The code is 0 for GPIO, 1 for peripheral A, 2 for B and 3 for C, and pad_owner bits [2i+1:2i] carry the code for pin i.
- R5: A GPIO-owned pin drives pad_oe from its direction bit and pad_out from its data bit. A pin owned by a peripheral takes both from that peripheral's enable and value inputs.
- R6: pad_pull_en is 1 only when the pin's pull-off bit (offset 6) is 0 and pad_oe is 0. pad_pull_up equals the data bit, so writing the pull direction on a GPIO output pin also changes its driven value.
- R7: While force_gpio is 1, each pin whose keep-owner bit is 0 is GPIO-owned regardless of its select bits. Pins whose bit is 1 keep their selected owner.
- R8: When force_gpio returns to 0, every pin reverts to its selected owner with no register write.
- R9: The slew register (offset 10) is read/write and appears unchanged on pad_slew.
- R10: Offset 0 reads pad_in through two flops. A change applied between clock edges is invisible after one rising edge and visible after the second.
- R11: Offsets 1, 2, 4, 5 and 12 to 15 read as zero. Writes to offsets 12 to 15 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 32 | Pad input levels |
| force_gpio | input | 1 | Hands non-kept pins back to GPIO |
| alt_a_oe | input | 32 | Peripheral A drive enables |
| alt_a_out | input | 32 | Peripheral A drive values |
| alt_b_oe | input | 32 | Peripheral B drive enables |
| alt_b_out | input | 32 | Peripheral B drive values |
| alt_c_oe | input | 32 | Peripheral C drive enables |
| alt_c_out | input | 32 | Peripheral C drive values |
| pad_oe | output | 32 | Per-pin drive enable |
| pad_out | output | 32 | Per-pin drive value |
| pad_pull_en | output | 32 | Per-pin pull enable |
| pad_pull_up | output | 32 | Per-pin pull direction (1 = up) |
| pad_owner | output | 64 | Two-bit owner code per pin |
| pad_slew | output | 32 | Per-pin slew control |

## Verification
The hardest case to reach is a bank where all four owners are live at once while the force input splits pins by their keep-owner bits. In that state a wrong owner code or a wrong drive source can hide behind identical peripheral values. The stimulus rotates the owner code per pin across four configurations and gives each peripheral distinct enable and value patterns. It then toggles force under two keep-owner masks, so every pin meets every owner, both force levels and both mask values. Input-synchronizer latency is probed by changing pad_in between edges and reading before, after one edge and after two.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_DATA     = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_DSET     = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_DCLR     = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_DIR      = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_DIRSET   = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_DIRCLR   = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_PULLOFF  = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_SELA     = 4'd7;
  localparam logic [ADDR_W-1:0] OFS_SELB     = 4'd8;
  localparam logic [ADDR_W-1:0] OFS_KEEP     = 4'd9;
  localparam logic [ADDR_W-1:0] OFS_SLEW     = 4'd10;
  localparam logic [ADDR_W-1:0] OFS_DATA_REG = 4'd11;

  typedef enum logic [1:0] {
    OWN_GPIO = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2,
    OWN_C    = 2'd3
  } owner_e;

  // Effective owner of one pin from its select bits and the override.
  function automatic owner_e pick_owner(input logic sel_a, input logic sel_b,
                                        input logic force_in, input logic keep);
    if (force_in && !keep) return OWN_GPIO;
    return owner_e'({sel_b, sel_a});
  endfunction

  // Write-one-to-act update of a bit vector.
  function automatic logic [31:0] set_clr(input logic [31:0] cur,
                                          input logic [31:0] set_m,
                                          input logic [31:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_out = stg[STAGES-1];

  // R10: the first stage captures the pad level of the previous edge
  a_r10_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stg[0] == $past(d_in));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  pins_sync,
  output logic [NPINS-1:0]  rdata,
  output logic [NPINS-1:0]  data_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  pull_off_q,
  output logic [NPINS-1:0]  sel_a_q,
  output logic [NPINS-1:0]  sel_b_q,
  output logic [NPINS-1:0]  keep_q,
  output logic [NPINS-1:0]  slew_q
);
  logic [NPINS-1:0] data_set, data_clr, dir_set, dir_clr;
  logic             hit_unmapped;

  always_comb begin
    data_set = '0;
    data_clr = '0;
    dir_set  = '0;
    dir_clr  = '0;
    if (wr_en) begin
      if (addr == OFS_DSET)   data_set = wdata;
      if (addr == OFS_DCLR)   data_clr = wdata;
      if (addr == OFS_DIRSET) dir_set  = wdata;
      if (addr == OFS_DIRCLR) dir_clr  = wdata;
    end
  end

  assign hit_unmapped = wr_en && (addr > OFS_DATA_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q     <= '0;
      dir_q      <= '0;
      pull_off_q <= '0;
      sel_a_q    <= '0;
      sel_b_q    <= '0;
      keep_q     <= '1;
      slew_q     <= '0;
    end else begin
      if (wr_en && addr == OFS_DATA) data_q <= wdata;
      else                           data_q <= set_clr(data_q, data_set, data_clr);
      if (wr_en && addr == OFS_DIR)  dir_q  <= wdata;
      else                           dir_q  <= set_clr(dir_q, dir_set, dir_clr);
      if (wr_en && addr == OFS_PULLOFF) pull_off_q <= wdata;
      if (wr_en && addr == OFS_SELA)    sel_a_q    <= wdata;
      if (wr_en && addr == OFS_SELB)    sel_b_q    <= wdata;
      if (wr_en && addr == OFS_KEEP)    keep_q     <= wdata;
      if (wr_en && addr == OFS_SLEW)    slew_q     <= wdata;
    end
  end

  always_comb begin
    case (addr)
      OFS_DATA:     rdata = pins_sync;
      OFS_DIR:      rdata = dir_q;
      OFS_PULLOFF:  rdata = pull_off_q;
      OFS_SELA:     rdata = sel_a_q;
      OFS_SELB:     rdata = sel_b_q;
      OFS_KEEP:     rdata = keep_q;
      OFS_SLEW:     rdata = slew_q;
      OFS_DATA_REG: rdata = data_q;
      default:      rdata = '0;
    endcase
  end

  // R2: a set write ORs the written ones into the data register
  a_r2_data_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_DSET) |=> data_q == ($past(data_q) | $past(wdata)));
  // R2: a clear write removes exactly the written ones
  a_r2_data_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_DCLR) |=> data_q == ($past(data_q) & ~$past(wdata)));
  // R3: direction set and clear
  a_r3_dir_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_DIRSET) |=> dir_q == ($past(dir_q) | $past(wdata)));
  a_r3_dir_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_DIRCLR) |=> dir_q == ($past(dir_q) & ~$past(wdata)));
  // R11: unmapped writes leave every register alone
  a_r11_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    hit_unmapped |=> ($stable(data_q) && $stable(dir_q) && $stable(pull_off_q) &&
                      $stable(sel_a_q) && $stable(sel_b_q) && $stable(keep_q) &&
                      $stable(slew_q)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_bank_pkg::*;
(
  input  logic       sel_a,
  input  logic       sel_b,
  input  logic       force_in,
  input  logic       keep,
  input  logic       gpio_dir,
  input  logic       gpio_data,
  input  logic       pull_off,
  input  logic       a_oe,
  input  logic       a_out,
  input  logic       b_oe,
  input  logic       b_out,
  input  logic       c_oe,
  input  logic       c_out,
  output logic       oe,
  output logic       dout,
  output logic       pull_en,
  output logic       pull_up,
  output logic [1:0] owner
);
  owner_e own;

  always_comb begin
    own = pick_owner(sel_a, sel_b, force_in, keep);
    unique case (own)
      OWN_GPIO: begin oe = gpio_dir; dout = gpio_data; end
      OWN_A:    begin oe = a_oe;     dout = a_out;     end
      OWN_B:    begin oe = b_oe;     dout = b_out;     end
      default:  begin oe = c_oe;     dout = c_out;     end
    endcase
  end

  assign owner   = own;
  assign pull_en = !pull_off && !oe;
  assign pull_up = gpio_data;
endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [NPINS-1:0]     bus_wdata,
  output logic [NPINS-1:0]     bus_rdata,
  input  logic [NPINS-1:0]     pad_in,
  input  logic                 force_gpio,
  input  logic [NPINS-1:0]     alt_a_oe,
  input  logic [NPINS-1:0]     alt_a_out,
  input  logic [NPINS-1:0]     alt_b_oe,
  input  logic [NPINS-1:0]     alt_b_out,
  input  logic [NPINS-1:0]     alt_c_oe,
  input  logic [NPINS-1:0]     alt_c_out,
  output logic [NPINS-1:0]     pad_oe,
  output logic [NPINS-1:0]     pad_out,
  output logic [NPINS-1:0]     pad_pull_en,
  output logic [NPINS-1:0]     pad_pull_up,
  output logic [2*NPINS-1:0]   pad_owner,
  output logic [NPINS-1:0]     pad_slew
);
  logic [NPINS-1:0] pins_sync;
  logic [NPINS-1:0] data_q, dir_q, pull_off_q, sel_a_q, sel_b_q, keep_q, slew_q;
  logic [NPINS-1:0] not_gpio;   // pin currently held by a peripheral

  gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pad_in), .q_out(pins_sync));

  gpio_bank_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .pins_sync(pins_sync), .rdata(bus_rdata), .data_q(data_q), .dir_q(dir_q),
    .pull_off_q(pull_off_q), .sel_a_q(sel_a_q), .sel_b_q(sel_b_q),
    .keep_q(keep_q), .slew_q(slew_q));

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      gpio_pin_mux u_mux (
        .sel_a(sel_a_q[i]), .sel_b(sel_b_q[i]), .force_in(force_gpio), .keep(keep_q[i]),
        .gpio_dir(dir_q[i]), .gpio_data(data_q[i]), .pull_off(pull_off_q[i]),
        .a_oe(alt_a_oe[i]), .a_out(alt_a_out[i]),
        .b_oe(alt_b_oe[i]), .b_out(alt_b_out[i]),
        .c_oe(alt_c_oe[i]), .c_out(alt_c_out[i]),
        .oe(pad_oe[i]), .dout(pad_out[i]), .pull_en(pad_pull_en[i]),
        .pull_up(pad_pull_up[i]), .owner(pad_owner[2*i+1:2*i]));
      assign not_gpio[i] = |pad_owner[2*i+1:2*i];
    end
  endgenerate

  assign pad_slew = slew_q;

  // R7: with the override active no non-kept pin is held by a peripheral
  a_r7_force_gpio: assert property (@(posedge clk) disable iff (!rst_n)
    force_gpio |-> (not_gpio & ~keep_q) == '0);
  // R5: GPIO-owned pins follow the direction and data registers
  a_r5_gpio_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ dir_q) | (pad_out ^ data_q)) & ~not_gpio) == '0);
  // R6: a pull is never enabled on a driven pin
  a_r6_pull_input: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pull_en & pad_oe) == '0);
  // R8: releasing the override restores the selected owners
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(force_gpio) && $stable(sel_a_q) && $stable(sel_b_q)) |->
      (not_gpio == (sel_a_q | sel_b_q)));
endmodule

// File: tb/test_gpio_mux_bank.sv
module test_gpio_mux_bank;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic          force_gpio = 1'b0;
  logic [N-1:0]  alt_a_oe = '0, alt_a_out = '0, alt_b_oe = '0, alt_b_out = '0;
  logic [N-1:0]  alt_c_oe = '0, alt_c_out = '0;
  logic [N-1:0]  pad_oe, pad_out, pad_pull_en, pad_pull_up, pad_slew;
  logic [2*N-1:0] pad_owner;

  int checks = 0;
  int errors = 0;

  // model of register contents kept by the bench
  logic [N-1:0] m_data = '0, m_dir = '0, m_poff = '0, m_sela = '0, m_selb = '0;
  logic [N-1:0] m_keep = '1;

  always #4 clk = ~clk;

  gpio_mux_bank i_gpio_mux_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .force_gpio(force_gpio), .alt_a_oe(alt_a_oe), .alt_a_out(alt_a_out),
    .alt_b_oe(alt_b_oe), .alt_b_out(alt_b_out), .alt_c_oe(alt_c_oe),
    .alt_c_out(alt_c_out), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
    .pad_owner(pad_owner), .pad_slew(pad_slew));

  task automatic chk(input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 4'd15; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // expected pad outputs computed from the requirement text
  task automatic check_pads(input string req);
    logic [N-1:0]   e_oe, e_out, e_pe;
    logic [2*N-1:0] e_own;
    for (int i = 0; i < N; i++) begin
      logic [1:0] o;
      o = (force_gpio && !m_keep[i]) ? 2'd0 : {m_selb[i], m_sela[i]};
      e_own[2*i +: 2] = o;
      case (o)
        2'd0: begin e_oe[i] = m_dir[i];    e_out[i] = m_data[i];    end
        2'd1: begin e_oe[i] = alt_a_oe[i]; e_out[i] = alt_a_out[i]; end
        2'd2: begin e_oe[i] = alt_b_oe[i]; e_out[i] = alt_b_out[i]; end
        default: begin e_oe[i] = alt_c_oe[i]; e_out[i] = alt_c_out[i]; end
      endcase
      e_pe[i] = !m_poff[i] && !e_oe[i];
    end
    #1;
    chk({req, " owner"}, pad_owner, e_own);
    chk({req, " oe"}, {32'd0, pad_oe}, {32'd0, e_oe});
    chk({req, " out"}, {32'd0, pad_out}, {32'd0, e_out});
    chk({req, " pull_en"}, {32'd0, pad_pull_en}, {32'd0, e_pe});
    chk({req, " pull_up"}, {32'd0, pad_pull_up}, {32'd0, m_data});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [N-1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_pads("R1");
    chk("R1 slew", {32'd0, pad_slew}, 64'd0);
    chk("R1 pull_en all", {32'd0, pad_pull_en}, {32'd0, 32'hFFFF_FFFF});
    rd(4'd9, r); chk("R1 keep reads ones", {32'd0, r}, {32'd0, 32'hFFFF_FFFF});

    // R2 data set/clear
    wr(4'd1, 32'hA5A5_0F0F); m_data = 32'hA5A5_0F0F;
    rd(4'd11, r); chk("R2 set", {32'd0, r}, {32'd0, m_data});
    wr(4'd2, 32'h0000_0F00); m_data = 32'hA5A5_000F;
    rd(4'd11, r); chk("R2 clr", {32'd0, r}, {32'd0, m_data});
    wr(4'd1, 32'h0); wr(4'd2, 32'h0);
    rd(4'd11, r); chk("R2 zero no effect", {32'd0, r}, {32'd0, m_data});
    wr(4'd0, 32'h1234_5678); m_data = 32'h1234_5678;
    rd(4'd11, r); chk("R2 direct", {32'd0, r}, {32'd0, m_data});

    // R3 direction set/clear
    wr(4'd4, 32'hFFFF_0000); m_dir = 32'hFFFF_0000;
    wr(4'd5, 32'h0F00_0000); m_dir = 32'hF0FF_0000;
    rd(4'd3, r); chk("R3 dir", {32'd0, r}, {32'd0, m_dir});
    check_pads("R5 gpio drive");

    // R6 pull disable and pull direction on an output pin
    wr(4'd6, 32'h0000_FF00); m_poff = 32'h0000_FF00;
    check_pads("R6 pull");
    wr(4'd2, 32'h0010_0000); m_data = m_data & ~32'h0010_0000;
    check_pads("R6 pull-dir on output");

    // R4/R5/R7/R8 sweep: rotating owners, force, two keep masks
    alt_a_oe = 32'h00FF_00FF; alt_a_out = 32'h0F0F_0F0F;
    alt_b_oe = 32'hFF00_FF00; alt_b_out = 32'h3333_3333;
    alt_c_oe = 32'hF0F0_F0F0; alt_c_out = 32'h5555_5555;
    for (int m = 0; m < 4; m++) begin
      logic [N-1:0] sa, sb;
      for (int i = 0; i < N; i++) begin
        logic [1:0] o;
        o = 2'((i + m) % 4);
        sa[i] = o[0]; sb[i] = o[1];
      end
      wr(4'd7, sa); m_sela = sa;
      wr(4'd8, sb); m_selb = sb;
      check_pads("R4 owner select");
      for (int k = 0; k < 2; k++) begin
        logic [N-1:0] kp;
        kp = (k == 0) ? 32'h0000_0000 : 32'hC3A5_5A3C;
        wr(4'd9, kp); m_keep = kp;
        @(negedge clk); force_gpio = 1'b1;
        check_pads("R7 forced");
        @(negedge clk); force_gpio = 1'b0;
        check_pads("R8 released");
      end
    end

    // R9 slew
    wr(4'd10, 32'h8001_7E42);
    rd(4'd10, r); chk("R9 slew read", {32'd0, r}, {32'd0, 32'h8001_7E42});
    chk("R9 slew pad", {32'd0, pad_slew}, {32'd0, 32'h8001_7E42});

    // R10 synchronizer latency
    @(negedge clk); pad_in = 32'hDEAD_BEEF;
    rd(4'd0, r); chk("R10 before edge", {32'd0, r}, 64'd0);
    @(negedge clk); rd(4'd0, r); chk("R10 one edge", {32'd0, r}, 64'd0);
    @(negedge clk); rd(4'd0, r); chk("R10 two edges", {32'd0, r}, {32'd0, 32'hDEAD_BEEF});

    // R11 write-only and unmapped offsets
    rd(4'd1, r); chk("R11 set reads 0", {32'd0, r}, 64'd0);
    rd(4'd5, r); chk("R11 dirclr reads 0", {32'd0, r}, 64'd0);
    for (int a = 12; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF);
    rd(4'd12, r); chk("R11 unmapped reads 0", {32'd0, r}, 64'd0);
    rd(4'd11, r); chk("R11 data untouched", {32'd0, r}, {32'd0, m_data});
    rd(4'd3, r);  chk("R11 dir untouched", {32'd0, r}, {32'd0, m_dir});
    check_pads("R11 pads untouched");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule